// File: doc/BRIEF.md
# Copy-Channel Control and Status Register File

This block is the software-facing register file of one descriptor-ring copy channel. Software reaches it through a word-addressed request port that always accepts and answers each read one cycle later. The registers hold where the descriptor ring lives (a 64-bit base split over two words, the next descriptor address, the number of ring entries), how far the engine may prefetch, the transfer size limit and a control word. The stored values drive the engine directly as level outputs, and a start command is turned into a single-cycle pulse.

The engine reports its progress back through event pulses: pause done, abort done, halt done, invalid descriptor, error and descriptor done. Each control flag and each interrupt status bit is set by its event and stays set until software writes a one to it. The control flags come out of reset set, so a driver that writes back the control word it has read clears them and issues its command in the same write. An event that arrives in the same cycle as a clear wins, so no completion is lost. One level interrupt line is raised from the interrupt status bits that are enabled.

Top module: `dmac_regs`

## Requirements
- R1: Word map: 0 ring base low, 1 ring base high, 2 next descriptor address, 3 ring entry count (CNT_W bits), 4 prefetch limit (PF_W bits), 5 control, 6 transfer size, 7 interrupt word. Bits above a narrow field are dropped on write and read as zero. A read request gives `rd_valid` and the data one cycle later. A write is visible from the next cycle, both in reads and on the ring outputs (`ring_base` is {high, low}).
- R2: Control bits 0 (pause), 1 (abort), 2 (write-back), 4 (stop at ring end) and 6:5 (descriptor mode: 0 block, 1 on-chip, 2 ring) are stored and drive `pause_req`, `abort_req`, `wb_en`, `stop_on_wrap` and `desc_mode`. A write with mode code 3 leaves the mode unchanged but updates the other fields.
- R3: Writing control with bit 3 set raises `start_pulse` for exactly the one following cycle. Bit 3 always reads 0.
- R4: After reset control reads 0x00001700 (flags 8, 9, 10 and 12 set), every other word reads 0, all outputs to the engine are 0 and `irq` is low.
- R5: Control flags are bit 8 (invalid descriptor), bit 9 (pause done), bit 10 (abort done) and bit 12 (halt done). Each is set by its event and cleared by a control write with a 1 in its position. A 0 leaves it unchanged. An event in the same cycle as a clear leaves the flag set.
- R6: Control bit 30 reads the `eng_busy` input as sampled with the read request.
- R7: A stored abort request drops in the cycle after an abort-done event.
- R8: Transfer size bits 2:0 take codes 0 to 5 (64 B to 2 KB) and 7 (4 B). A write with code 6 is ignored.
- R9: Interrupt status sits in bits 21:16 of word 7: bit 16 error, 17 invalid descriptor, 18 descriptor done, 19 abort done, 20 pause done, 21 halt done. Each is set by its event and cleared by writing 1 to it, and an event wins over a clear in the same cycle.
- R10: Interrupt enables sit in bits 5:0 of word 7, with the same order as the status bits. Only bits 0, 1, 3, 4 and 5 can be written; bit 2 and bits 15:6 read 0.
- R11: `irq` is high exactly when some status bit is set and enabled, with descriptor-done status always counted as enabled. It follows the registered status, one cycle after the event or the write.
- R12: A descriptor-done event without `evt_desc_irq` sets no status bit.
- R13: A word address above 7 reads 0, and a write to it changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Register request present |
| req_ready | output | 1 | Request accepted (always high) |
| req_write | input | 1 | 1 write, 0 read |
| req_addr | input | ADDR_W | Word address |
| req_wdata | input | 32 | Write data |
| rd_valid | output | 1 | Read data valid |
| rd_data | output | 32 | Read data |
| eng_busy | input | 1 | Engine has a transfer in progress |
| evt_error | input | 1 | Engine error event |
| evt_bad_desc | input | 1 | Invalid descriptor event |
| evt_desc_done | input | 1 | Descriptor completed |
| evt_desc_irq | input | 1 | Completed descriptor asked for an interrupt |
| evt_pause_done | input | 1 | Graceful pause finished |
| evt_abort_done | input | 1 | Abort finished |
| evt_halt_done | input | 1 | Immediate halt finished |
| ring_base | output | 64 | Ring base address |
| ring_next | output | 32 | Next descriptor address |
| ring_count | output | CNT_W | Ring entry count |
| prefetch_lim | output | PF_W | Prefetch limit |
| start_pulse | output | 1 | Start command, one cycle |
| pause_req | output | 1 | Graceful pause request |
| abort_req | output | 1 | Abort request |
| wb_en | output | 1 | Descriptor write-back enable |
| stop_on_wrap | output | 1 | Stop at ring end |
| desc_mode | output | 2 | Descriptor mode |
| xfer_code | output | 3 | Transfer size code |
| irq | output | 1 | Level interrupt |

## Verification
The bench builds the block with a 4-bit word address, a 12-bit ring count and a 4-bit prefetch limit. The wider address puts eight unmapped words within reach, so reads that return zero and writes that do nothing can be observed. The narrow prefetch field makes bit dropping on a write visible. A 12-bit count holds a 2048-entry ring while still dropping the top bit of 0x1FFF, and a long stretch of random requests and events mixed together hits clear-versus-set collisions at every flag.

// File: rtl/dmac_pkg.sv
`timescale 1ns/1ps
package dmac_pkg;
    // word addresses
    localparam int REG_BASE_LO = 0;
    localparam int REG_BASE_HI = 1;
    localparam int REG_NEXT    = 2;
    localparam int REG_COUNT   = 3;
    localparam int REG_PREF    = 4;
    localparam int REG_CTRL    = 5;
    localparam int REG_XSIZE   = 6;
    localparam int REG_INT     = 7;
    localparam int NUM_REGS    = 8;

    // control word bit positions (decoded by software)
    localparam int CB_PAUSE   = 0;
    localparam int CB_ABORT   = 1;
    localparam int CB_WB      = 2;
    localparam int CB_START   = 3;
    localparam int CB_STOP    = 4;
    localparam int CB_MODE    = 5;
    localparam int CB_BADDESC = 8;
    localparam int CB_PDONE   = 9;
    localparam int CB_ADONE   = 10;
    localparam int CB_HDONE   = 12;
    localparam int CB_BUSY    = 30;

    // interrupt bit positions
    localparam int IRQ_BITS   = 6;
    localparam int IST_SHIFT  = 16;
    localparam logic [IRQ_BITS-1:0] IEN_WMASK  = 6'b111011;
    localparam logic [IRQ_BITS-1:0] IRQ_ALWAYS = 6'b000100;

    localparam int FLAG_BITS = 4;
    localparam logic [1:0] MODE_RSVD = 2'd3;
    localparam logic [2:0] XSZ_RSVD  = 3'd6;

    typedef struct packed {
        logic       pause;
        logic       abort;
        logic       wb;
        logic       stop;
        logic [1:0] mode;
    } ctrl_t;
endpackage

// File: rtl/dmac_flagbank.sv
`timescale 1ns/1ps
module dmac_flagbank #(
    parameter int W = 4,
    parameter logic [W-1:0] RST = '0
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] set,
    input  logic [W-1:0] clr,
    output logic [W-1:0] q
);
    logic [W-1:0] q_d, q_q;

    // a set in the same cycle as a clear keeps the bit
    always_comb begin
        q_d = (q_q & ~clr) | set;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q_q <= RST;
        else        q_q <= q_d;
    end

    assign q = q_q;
endmodule

// File: rtl/dmac_readmux.sv
`timescale 1ns/1ps
module dmac_readmux
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 12,
    parameter int PF_W   = 8
) (
    input  logic [ADDR_W-1:0]    addr,
    input  logic [31:0]          base_lo,
    input  logic [31:0]          base_hi,
    input  logic [31:0]          next_addr,
    input  logic [CNT_W-1:0]     cnt,
    input  logic [PF_W-1:0]      pref,
    input  ctrl_t                ctrl,
    input  logic [FLAG_BITS-1:0] flags,
    input  logic                 busy,
    input  logic [2:0]           xsz,
    input  logic [IRQ_BITS-1:0]  ien,
    input  logic [IRQ_BITS-1:0]  ist,
    output logic [31:0]          data
);
    always_comb begin
        data = '0;
        case (addr)
            ADDR_W'(REG_BASE_LO): data = base_lo;
            ADDR_W'(REG_BASE_HI): data = base_hi;
            ADDR_W'(REG_NEXT):    data = next_addr;
            ADDR_W'(REG_COUNT):   data[CNT_W-1:0] = cnt;
            ADDR_W'(REG_PREF):    data[PF_W-1:0] = pref;
            ADDR_W'(REG_CTRL): begin
                data[CB_PAUSE]           = ctrl.pause;
                data[CB_ABORT]           = ctrl.abort;
                data[CB_WB]              = ctrl.wb;
                data[CB_STOP]            = ctrl.stop;
                data[CB_MODE+1:CB_MODE]  = ctrl.mode;
                data[CB_BADDESC]         = flags[0];
                data[CB_PDONE]           = flags[1];
                data[CB_ADONE]           = flags[2];
                data[CB_HDONE]           = flags[3];
                data[CB_BUSY]            = busy;
            end
            ADDR_W'(REG_XSIZE):   data[2:0] = xsz;
            ADDR_W'(REG_INT): begin
                data[IRQ_BITS-1:0]                   = ien;
                data[IST_SHIFT+IRQ_BITS-1:IST_SHIFT] = ist;
            end
            default: data = '0;
        endcase
    end
endmodule

// File: rtl/dmac_regs.sv
`timescale 1ns/1ps
module dmac_regs
    import dmac_pkg::*;
#(
    parameter int ADDR_W = 3,
    parameter int CNT_W  = 12,
    parameter int PF_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [31:0]       req_wdata,
    output logic              rd_valid,
    output logic [31:0]       rd_data,
    input  logic              eng_busy,
    input  logic              evt_error,
    input  logic              evt_bad_desc,
    input  logic              evt_desc_done,
    input  logic              evt_desc_irq,
    input  logic              evt_pause_done,
    input  logic              evt_abort_done,
    input  logic              evt_halt_done,
    output logic [63:0]       ring_base,
    output logic [31:0]       ring_next,
    output logic [CNT_W-1:0]  ring_count,
    output logic [PF_W-1:0]   prefetch_lim,
    output logic              start_pulse,
    output logic              pause_req,
    output logic              abort_req,
    output logic              wb_en,
    output logic              stop_on_wrap,
    output logic [1:0]        desc_mode,
    output logic [2:0]        xfer_code,
    output logic              irq
);
    localparam logic [FLAG_BITS-1:0] FLAG_RST = '1;

    typedef struct packed {
        logic [31:0]         base_lo;
        logic [31:0]         base_hi;
        logic [31:0]         next_addr;
        logic [CNT_W-1:0]    cnt;
        logic [PF_W-1:0]     pref;
        ctrl_t               ctrl;
        logic                start;
        logic [2:0]          xsz;
        logic [IRQ_BITS-1:0] ien;
        logic                rv;
        logic [31:0]         rd;
    } state_t;

    state_t st_d, st_q;

    // one select line per mapped word
    logic [NUM_REGS-1:0] sel;
    genvar gi;
    generate
        for (gi = 0; gi < NUM_REGS; gi++) begin : g_sel
            assign sel[gi] = req_valid && (req_addr == ADDR_W'(gi));
        end
    endgenerate

    logic wr_ctrl, wr_int, rd_req;
    assign wr_ctrl = req_write && sel[REG_CTRL];
    assign wr_int  = req_write && sel[REG_INT];
    assign rd_req  = req_valid && !req_write;

    // sticky control flags: [0] bad desc, [1] pause done, [2] abort done, [3] halt done
    logic [FLAG_BITS-1:0] ctrl_flags, flag_set, flag_clr;
    assign flag_set = {evt_halt_done, evt_abort_done, evt_pause_done, evt_bad_desc};
    assign flag_clr = {req_wdata[CB_HDONE], req_wdata[CB_ADONE],
                       req_wdata[CB_PDONE], req_wdata[CB_BADDESC]} & {FLAG_BITS{wr_ctrl}};

    dmac_flagbank #(.W(FLAG_BITS), .RST(FLAG_RST)) u_flags (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (flag_set),
        .clr   (flag_clr),
        .q     (ctrl_flags)
    );

    // interrupt status, write one to clear
    logic [IRQ_BITS-1:0] irq_stat, ist_set, ist_clr;
    assign ist_set = {evt_halt_done, evt_pause_done, evt_abort_done,
                      evt_desc_done && evt_desc_irq, evt_bad_desc, evt_error};
    assign ist_clr = req_wdata[IST_SHIFT+IRQ_BITS-1:IST_SHIFT] & {IRQ_BITS{wr_int}};

    dmac_flagbank #(.W(IRQ_BITS), .RST('0)) u_ist (
        .clk   (clk),
        .rst_n (rst_n),
        .set   (ist_set),
        .clr   (ist_clr),
        .q     (irq_stat)
    );

    logic [31:0] rd_mux;
    dmac_readmux #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .PF_W(PF_W)) u_rmux (
        .addr      (req_addr),
        .base_lo   (st_q.base_lo),
        .base_hi   (st_q.base_hi),
        .next_addr (st_q.next_addr),
        .cnt       (st_q.cnt),
        .pref      (st_q.pref),
        .ctrl      (st_q.ctrl),
        .flags     (ctrl_flags),
        .busy      (eng_busy),
        .xsz       (st_q.xsz),
        .ien       (st_q.ien),
        .ist       (irq_stat),
        .data      (rd_mux)
    );

    always_comb begin
        st_d       = st_q;
        st_d.start = 1'b0;
        st_d.rv    = 1'b0;
        if (req_write) begin
            if (sel[REG_BASE_LO]) st_d.base_lo   = req_wdata;
            if (sel[REG_BASE_HI]) st_d.base_hi   = req_wdata;
            if (sel[REG_NEXT])    st_d.next_addr = req_wdata;
            if (sel[REG_COUNT])   st_d.cnt       = req_wdata[CNT_W-1:0];
            if (sel[REG_PREF])    st_d.pref      = req_wdata[PF_W-1:0];
            if (sel[REG_CTRL]) begin
                st_d.ctrl.pause = req_wdata[CB_PAUSE];
                st_d.ctrl.abort = req_wdata[CB_ABORT];
                st_d.ctrl.wb    = req_wdata[CB_WB];
                st_d.ctrl.stop  = req_wdata[CB_STOP];
                st_d.start      = req_wdata[CB_START];
                if (req_wdata[CB_MODE+1:CB_MODE] != MODE_RSVD)
                    st_d.ctrl.mode = req_wdata[CB_MODE+1:CB_MODE];
            end
            if (sel[REG_XSIZE] && req_wdata[2:0] != XSZ_RSVD)
                st_d.xsz = req_wdata[2:0];
            if (sel[REG_INT])
                st_d.ien = req_wdata[IRQ_BITS-1:0] & IEN_WMASK;
        end
        if (evt_abort_done)
            st_d.ctrl.abort = 1'b0;
        if (rd_req) begin
            st_d.rv = 1'b1;
            st_d.rd = rd_mux;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign req_ready    = 1'b1;
    assign rd_valid     = st_q.rv;
    assign rd_data      = st_q.rd;
    assign ring_base    = {st_q.base_hi, st_q.base_lo};
    assign ring_next    = st_q.next_addr;
    assign ring_count   = st_q.cnt;
    assign prefetch_lim = st_q.pref;
    assign start_pulse  = st_q.start;
    assign pause_req    = st_q.ctrl.pause;
    assign abort_req    = st_q.ctrl.abort;
    assign wb_en        = st_q.ctrl.wb;
    assign stop_on_wrap = st_q.ctrl.stop;
    assign desc_mode    = st_q.ctrl.mode;
    assign xfer_code    = st_q.xsz;
    assign irq          = |(irq_stat & (st_q.ien | IRQ_ALWAYS));
endmodule

// File: rtl/dmac_regs_chk.sv
`timescale 1ns/1ps
module dmac_regs_chk #(
    parameter int ADDR_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_valid,
    input logic              req_write,
    input logic [ADDR_W-1:0] req_addr,
    input logic [31:0]       req_wdata,
    input logic              evt_error,
    input logic              evt_bad_desc,
    input logic              evt_desc_done,
    input logic              evt_desc_irq,
    input logic              evt_pause_done,
    input logic              evt_abort_done,
    input logic              evt_halt_done,
    input logic              rd_valid,
    input logic              start_pulse,
    input logic              abort_req,
    input logic [2:0]        xfer_code,
    input logic              irq,
    input logic [3:0]        flags,
    input logic [5:0]        ist
);
    logic any_evt;
    assign any_evt = evt_error | evt_bad_desc | evt_desc_done | evt_pause_done
                   | evt_abort_done | evt_halt_done;

    // R1
    rd_answer_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_write) |=> rd_valid);

    // R3
    start_origin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse |-> $past(req_valid && req_write && req_addr == ADDR_W'(5)
                              && (req_wdata & 32'h8) != 32'h0));

    // R5
    pause_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_pause_done |=> flags[1]);

    // R7
    abort_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        evt_abort_done |=> !abort_req);

    // R8
    xsz_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == ADDR_W'(6) && req_wdata == 32'd6)
        |=> $stable(xfer_code));

    // R11
    irq_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_write && req_addr == ADDR_W'(7)
         && req_wdata == 32'h003F_0000 && !any_evt) |=> !irq);

    // R12
    desc_noreq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (evt_desc_done && !evt_desc_irq && !ist[2]) |=> !ist[2]);
endmodule

bind dmac_regs dmac_regs_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .req_valid      (req_valid),
    .req_write      (req_write),
    .req_addr       (req_addr),
    .req_wdata      (req_wdata),
    .evt_error      (evt_error),
    .evt_bad_desc   (evt_bad_desc),
    .evt_desc_done  (evt_desc_done),
    .evt_desc_irq   (evt_desc_irq),
    .evt_pause_done (evt_pause_done),
    .evt_abort_done (evt_abort_done),
    .evt_halt_done  (evt_halt_done),
    .rd_valid       (rd_valid),
    .start_pulse    (start_pulse),
    .abort_req      (abort_req),
    .xfer_code      (xfer_code),
    .irq            (irq),
    .flags          (ctrl_flags),
    .ist            (irq_stat)
);

// File: tb/sim_dmac_regs.sv
`timescale 1ns/1ps
module sim_dmac_regs;
    localparam int AW = 4;
    localparam int CW = 12;
    localparam int PW = 4;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n;
    logic          b_valid, b_write, busy;
    logic [AW-1:0] b_addr;
    logic [31:0]   b_wdata;
    logic e_err, e_bad, e_dd, e_di, e_pd, e_ad, e_hd;

    logic          req_ready, rd_valid, start_pulse, pause_req, abort_req;
    logic          wb_en, stop_on_wrap, irq;
    logic [31:0]   rd_data, ring_next;
    logic [63:0]   ring_base;
    logic [CW-1:0] ring_count;
    logic [PW-1:0] prefetch_lim;
    logic [1:0]    desc_mode;
    logic [2:0]    xfer_code;

    dmac_regs #(.ADDR_W(AW), .CNT_W(CW), .PF_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(b_valid), .req_ready(req_ready),
        .req_write(b_write), .req_addr(b_addr), .req_wdata(b_wdata),
        .rd_valid(rd_valid), .rd_data(rd_data), .eng_busy(busy),
        .evt_error(e_err), .evt_bad_desc(e_bad), .evt_desc_done(e_dd),
        .evt_desc_irq(e_di), .evt_pause_done(e_pd), .evt_abort_done(e_ad),
        .evt_halt_done(e_hd), .ring_base(ring_base), .ring_next(ring_next),
        .ring_count(ring_count), .prefetch_lim(prefetch_lim),
        .start_pulse(start_pulse), .pause_req(pause_req), .abort_req(abort_req),
        .wb_en(wb_en), .stop_on_wrap(stop_on_wrap), .desc_mode(desc_mode),
        .xfer_code(xfer_code), .irq(irq)
    );

    int total = 0;
    int bad   = 0;
    bit finished = 1'b0;

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    // ---------------- behavioural reference model ----------------
    logic [31:0]   m_blo, m_bhi, m_nx, m_rd;
    logic [CW-1:0] m_cnt;
    logic [PW-1:0] m_pf;
    logic          m_pause, m_abort, m_wb, m_stop, m_start, m_rv;
    logic [1:0]    m_mode;
    logic [2:0]    m_xs;
    logic [3:0]    m_fl;   // 8, 9, 10, 12
    logic [5:0]    m_ien, m_ist;

    function automatic logic [31:0] mread(input int a);
        logic [31:0] v = 32'h0;
        case (a)
            0: v = m_blo;
            1: v = m_bhi;
            2: v = m_nx;
            3: v = 32'(m_cnt);
            4: v = 32'(m_pf);
            5: begin
                v = 32'(m_pause) | (32'(m_abort) << 1) | (32'(m_wb) << 2)
                  | (32'(m_stop) << 4) | (32'(m_mode) << 5)
                  | (32'(m_fl[0]) << 8) | (32'(m_fl[1]) << 9)
                  | (32'(m_fl[2]) << 10) | (32'(m_fl[3]) << 12)
                  | (32'(busy) << 30);
            end
            6: v = 32'(m_xs);
            7: v = 32'(m_ien) | (32'(m_ist) << 16);
            default: v = 32'h0;
        endcase
        return v;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            m_blo <= 0; m_bhi <= 0; m_nx <= 0; m_cnt <= 0; m_pf <= 0;
            m_pause <= 0; m_abort <= 0; m_wb <= 0; m_stop <= 0; m_mode <= 0;
            m_start <= 0; m_xs <= 0; m_fl <= 4'hF; m_ien <= 0; m_ist <= 0;
            m_rv <= 0; m_rd <= 0;
        end else begin
            logic [3:0] fl;
            logic [5:0] is;
            logic       ab;
            int a;
            a  = int'(b_addr);
            fl = m_fl;
            is = m_ist;
            ab = m_abort;
            m_start <= 1'b0;
            m_rv    <= 1'b0;
            if (b_valid && b_write) begin
                case (a)
                    0: m_blo <= b_wdata;
                    1: m_bhi <= b_wdata;
                    2: m_nx  <= b_wdata;
                    3: m_cnt <= b_wdata[CW-1:0];
                    4: m_pf  <= b_wdata[PW-1:0];
                    5: begin
                        m_pause <= b_wdata[0];
                        ab       = b_wdata[1];
                        m_wb    <= b_wdata[2];
                        m_start <= b_wdata[3];
                        m_stop  <= b_wdata[4];
                        if (b_wdata[6:5] != 2'd3) m_mode <= b_wdata[6:5];
                        if (b_wdata[8])  fl[0] = 1'b0;
                        if (b_wdata[9])  fl[1] = 1'b0;
                        if (b_wdata[10]) fl[2] = 1'b0;
                        if (b_wdata[12]) fl[3] = 1'b0;
                    end
                    6: if (b_wdata[2:0] != 3'd6) m_xs <= b_wdata[2:0];
                    7: begin
                        m_ien <= {b_wdata[5:3], 1'b0, b_wdata[1:0]};
                        is = is & ~b_wdata[21:16];
                    end
                    default: ;
                endcase
            end
            if (e_bad) begin fl[0] = 1'b1; is[1] = 1'b1; end
            if (e_pd)  begin fl[1] = 1'b1; is[4] = 1'b1; end
            if (e_ad)  begin fl[2] = 1'b1; is[3] = 1'b1; ab = 1'b0; end
            if (e_hd)  begin fl[3] = 1'b1; is[5] = 1'b1; end
            if (e_err) is[0] = 1'b1;
            if (e_dd && e_di) is[2] = 1'b1;
            m_fl    <= fl;
            m_ist   <= is;
            m_abort <= ab;
            if (b_valid && !b_write) begin
                m_rv <= 1'b1;
                m_rd <= mread(a);
            end
        end
    end

    // per-cycle comparison away from the edge
    always @(posedge clk) begin
        #1;
        if (rst_n && !finished) begin
            check("R1 rd_valid", rd_valid, m_rv);
            if (m_rv) check("R1 rd_data", rd_data, m_rd);
            check("R1 ring_base", ring_base, {m_bhi, m_blo});
            check("R1 ring_next", ring_next, m_nx);
            check("R1 ring_count", ring_count, m_cnt);
            check("R1 prefetch", prefetch_lim, m_pf);
            check("R2 ctrl outs", {pause_req, wb_en, stop_on_wrap, desc_mode},
                  {m_pause, m_wb, m_stop, m_mode});
            check("R3 start_pulse", start_pulse, m_start);
            check("R7 abort_req", abort_req, m_abort);
            check("R8 xfer_code", xfer_code, m_xs);
            check("R11 irq", irq, |(m_ist & (m_ien | 6'b000100)));
        end
    end

    // ---------------- stimulus ----------------
    task automatic op(input bit v, input bit w, input int a, input logic [31:0] d,
                      input logic [6:0] ev);
        @(negedge clk);
        b_valid = v; b_write = w; b_addr = AW'(a); b_wdata = d;
        {e_hd, e_ad, e_pd, e_di, e_dd, e_bad, e_err} = ev;
        @(posedge clk);
        #1;
        b_valid = 0; b_write = 0;
        {e_hd, e_ad, e_pd, e_di, e_dd, e_bad, e_err} = '0;
    endtask

    task automatic wr(input int a, input logic [31:0] d);
        op(1, 1, a, d, 7'h0);
    endtask

    task automatic rd_expect(input string tag, input int a, input logic [31:0] exp);
        op(1, 0, a, 32'h0, 7'h0);
        check(tag, rd_data, exp);
    endtask

    localparam logic [6:0] EV_ERR = 7'h01, EV_BAD = 7'h02, EV_DD = 7'h04,
                           EV_DI = 7'h08, EV_PD = 7'h10, EV_AD = 7'h20;

    initial begin
        #1000000;
        if (!finished) begin
            finished = 1'b1;
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst_n = 0; b_valid = 0; b_write = 0; b_addr = '0; b_wdata = '0; busy = 0;
        {e_hd, e_ad, e_pd, e_di, e_dd, e_bad, e_err} = '0;
        repeat (4) @(posedge clk);
        #1; rst_n = 1;

        // R4 reset state
        check("R4 irq at reset", irq, 1'b0);
        check("R4 engine outs at reset", {start_pulse, pause_req, abort_req, wb_en, stop_on_wrap, desc_mode, xfer_code}, '0);
        rd_expect("R4 ctrl reset", 5, 32'h0000_1700);
        rd_expect("R4 int reset", 7, 32'h0);
        rd_expect("R4 base reset", 0, 32'h0);

        // R1 ring registers and narrow fields
        wr(0, 32'hDEAD_BEEF); wr(1, 32'h1234_5678); wr(2, 32'h0BAD_F00D);
        wr(3, 32'h1FFF); wr(4, 32'hAB);
        rd_expect("R1 count dropped bit", 3, 32'h0FFF);
        rd_expect("R1 prefetch dropped bits", 4, 32'hB);
        rd_expect("R1 next addr", 2, 32'h0BAD_F00D);
        check("R1 ring_base out", ring_base, 64'h1234_5678_DEAD_BEEF);

        // R3 start pulse, R5 clear-and-command
        wr(5, 32'h0000_175C);
        check("R3 start high", start_pulse, 1'b1);
        @(posedge clk); #1;
        check("R3 start one cycle", start_pulse, 1'b0);
        rd_expect("R5 flags cleared, R3 bit reads 0", 5, 32'h0000_0054);

        // R6 busy
        busy = 1;
        rd_expect("R6 busy bit", 5, 32'h4000_0054);
        busy = 0;

        // R2 reserved mode
        wr(5, 32'h60);
        rd_expect("R2 mode 3 ignored", 5, 32'h40);
        check("R2 desc_mode", desc_mode, 2'd2);

        // R8 transfer size
        wr(6, 3); rd_expect("R8 size 3", 6, 3);
        wr(6, 6); rd_expect("R8 code 6 ignored", 6, 3);
        wr(6, 7); rd_expect("R8 size 7", 6, 7);

        // R5 / R9 / R10 / R11 events and enables
        op(0, 0, 0, 0, EV_PD);
        rd_expect("R5 pause flag set", 5, 32'h240);
        rd_expect("R9 pause status", 7, 32'h0010_0000);
        check("R11 irq masked", irq, 1'b0);
        wr(7, 32'h3F);
        rd_expect("R10 enable mask", 7, 32'h0010_003B);
        check("R11 irq enabled", irq, 1'b1);
        wr(7, 32'h0010_003B);
        check("R11 irq after w1c", irq, 1'b0);
        rd_expect("R9 w1c", 7, 32'h3B);

        // R12 descriptor done without request, then with
        wr(7, 0);
        op(0, 0, 0, 0, EV_DD);
        rd_expect("R12 no status", 7, 32'h0);
        op(0, 0, 0, 0, EV_DD | EV_DI);
        check("R11 desc done always on", irq, 1'b1);
        rd_expect("R9 desc status", 7, 32'h0004_0000);
        wr(7, 32'h0004_0000);
        check("R11 irq drop", irq, 1'b0);

        // R7 abort handshake
        wr(5, 32'h2);
        check("R7 abort raised", abort_req, 1'b1);
        op(0, 0, 0, 0, EV_AD);
        check("R7 abort dropped", abort_req, 1'b0);
        rd_expect("R5 abort done flag", 5, 32'h600);
        rd_expect("R9 abort status", 7, 32'h0008_0000);

        // R5 / R9 set wins over clear
        op(1, 1, 5, 32'h200, EV_PD);
        rd_expect("R5 set wins", 5, 32'h600);
        op(1, 1, 7, 32'h0010_0000, EV_PD);
        rd_expect("R9 set wins", 7, 32'h0018_0000);

        // R13 unmapped words
        wr(9, 32'hFFFF_FFFF);
        rd_expect("R13 unmapped read", 9, 32'h0);
        rd_expect("R13 no alias", 1, 32'h1234_5678);

        // mixed random traffic against the model
        for (int i = 0; i < 3000; i++) begin
            logic [31:0] r, d;
            logic [6:0]  ev;
            r  = $urandom;
            d  = $urandom;
            ev = ((r[31:28] == 4'h0) ? 7'(r[26:20]) : 7'h0);
            busy = r[19];
            op(r[0] | r[1], r[2], int'(r[7:4]), d, ev);
        end

        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule